// File: doc/BRIEF.md
# Depth-First Sphere Search Controller

This block steers a depth-first tree search over the layers of an upper-triangular channel model, for a run-time chosen number of transmit antennas between 2 and a synthesis-time maximum (16 by default). The search begins at the deepest layer, the tree root, and works toward layer 0. Each node it visits carries a cumulative metric: the partial Euclidean distance summed over the layers already decided. The metric can only grow with depth. Any candidate whose running metric reaches the current radius is therefore dropped together with its whole subtree.

Candidate points and their distance increments come from an external enumerator. The block asks for the candidate of a given rank at a given layer, and the enumerator answers with the symbol, its increment and whether the candidate exists. Candidates must arrive in non-decreasing increment order. The radius starts at the largest metric value and shrinks to each better leaf metric that is found. A shift-register path store moves one layer forward or back with each step. When the search backs out past the root, the block pulses `done` and presents the best symbol vector and its metric.

Top module: `sphere_dfs_ctrl`

## Requirements
- R1: `start` sampled high while idle loads the antenna count from `cfg_ant`. Values below 2 are treated as 2 and values above MAX_ANT as MAX_ANT. The first request names layer count-1 with rank 0, and `busy` rises.
- R2: `req_valid` is a one-cycle pulse carrying `req_level` and `req_rank`. No new request is issued until a response has been taken. A `rsp_valid` that arrives in the request cycle, or while idle, is ignored.
- R3: At layer L>0, a response with `rsp_avail`=1 is accepted when its candidate metric (parent metric plus `rsp_inc`) is strictly below the radius. The search then descends: the next request is layer L-1, rank 0.
- R4: A response with `rsp_avail`=0, or with a candidate metric at or above the radius, ends layer L. The next request is layer L+1 with the rank after the one last accepted there.
- R5: An accepted candidate at layer 0 is a leaf. Its metric becomes the new radius and the best metric, and the path becomes the best vector. The next request is layer 0 with rank+1. The radius never increases during a search.
- R6: Metric sums saturate at 2^MET_W-1 and never wrap. A saturated metric equals the initial radius and is therefore pruned.
- R7: A candidate whose metric equals the radius is pruned. Among leaves with equal metric, the first one found is kept.
- R8: Ending the root layer produces a one-cycle `done` with `busy` low. In `best_vec`, slot i (bits i*SYM_W+SYM_W-1 down to i*SYM_W) holds the symbol chosen at layer i, and slots at or above the count are zero. If no leaf was accepted, `best_met` is all-ones and `best_vec` is zero.
- R9: `start` is ignored while busy and in the `done` cycle. `best_vec` and `best_met` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken only while idle) |
| cfg_ant | input | $clog2(MAX_ANT+1) | Number of antennas (tree depth) |
| req_valid | output | 1 | Candidate request pulse |
| req_level | output | $clog2(MAX_ANT) | Layer of the requested candidate |
| req_rank | output | RANK_W | Rank of the requested candidate within its layer |
| rsp_valid | input | 1 | Enumerator response strobe |
| rsp_avail | input | 1 | A candidate exists at the requested rank |
| rsp_sym | input | SYM_W | Symbol of the candidate |
| rsp_inc | input | MET_W | Distance increment of the candidate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_vec | output | MAX_ANT*SYM_W | Best symbol vector, one slot per layer |
| best_met | output | MET_W | Metric of the best vector |

## Verification
Two pairs of events can coincide, and both are provoked deliberately. In the first, a stray response strobe is placed in the very cycle a request is issued, with a zero increment that would win if it were taken. The bench judges the pair by checking that the request sequence and the final vector still match its own exhaustive search. In the second, a fresh `start` is driven in the same cycle as the `done` pulse, and another one in the middle of a search. The bench then confirms that `busy` and `req_valid` stay low and that the result is unchanged. Around these cases, a bench-side model predicts every request: the descent after an accepted candidate, the rank after a backtrack, and the exact cycle of completion, including saturating and tie-valued metrics.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } dfs_state_e;
endpackage

// File: rtl/sd_path_store.sv
module sd_path_store #(
  parameter int DEPTH = 16,
  parameter int W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic                 pop,
  input  logic [W-1:0]         din,
  output logic [DEPTH*W-1:0]   flat
);
  logic [W-1:0] slot     [DEPTH];
  logic [W-1:0] from_low [DEPTH];
  logic [W-1:0] from_high[DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign from_low[i] = din;
    end else begin : g_mid
      assign from_low[i] = slot[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_high[i] = '0;
    end else begin : g_inner
      assign from_high[i] = slot[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot[i] <= '0;
      else if (clr)    slot[i] <= '0;
      else if (push)   slot[i] <= from_low[i];
      else if (pop)    slot[i] <= from_high[i];
    end
    assign flat[i*W +: W] = slot[i];
  end

  // R3 / R4: a step goes one way only
  a_r3_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr, push, pop}));
endmodule

// File: rtl/sd_level_mem.sv
module sd_level_mem #(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 4,
  parameter int RANK_W = 7,
  parameter int MET_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [LVL_W-1:0]  init_lvl,
  input  logic              bump,
  input  logic [LVL_W-1:0]  bump_lvl,
  input  logic              desc,
  input  logic [LVL_W-1:0]  desc_tgt,
  input  logic [MET_W-1:0]  desc_met,
  input  logic [LVL_W-1:0]  rd_lvl,
  output logic [RANK_W-1:0] rd_rank,
  output logic [MET_W-1:0]  rd_base
);
  logic [RANK_W-1:0] rank_q [DEPTH];
  logic [MET_W-1:0]  base_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic hit_init, hit_desc, hit_bump;
    assign hit_init = init && (init_lvl == LVL_W'(i));
    assign hit_desc = desc && (desc_tgt == LVL_W'(i));
    assign hit_bump = bump && (bump_lvl == LVL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q[i] <= '0;
        base_q[i] <= '0;
      end else if (hit_init || hit_desc) begin
        rank_q[i] <= '0;
        base_q[i] <= hit_init ? '0 : desc_met;
      end else if (hit_bump && rank_q[i] != '1) begin
        rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  assign rd_rank = rank_q[rd_lvl];
  assign rd_base = base_q[rd_lvl];
endmodule

// File: rtl/sphere_dfs_ctrl.sv
module sphere_dfs_ctrl #(
  parameter  int MAX_ANT = 16,
  parameter  int SYM_W   = 6,
  parameter  int MET_W   = 16,
  parameter  int RANK_W  = 7,
  localparam int LVL_W   = $clog2(MAX_ANT),
  localparam int CNT_W   = $clog2(MAX_ANT + 1),
  localparam int VEC_W   = MAX_ANT * SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_ant,
  output logic              req_valid,
  output logic [LVL_W-1:0]  req_level,
  output logic [RANK_W-1:0] req_rank,
  input  logic              rsp_valid,
  input  logic              rsp_avail,
  input  logic [SYM_W-1:0]  rsp_sym,
  input  logic [MET_W-1:0]  rsp_inc,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  best_vec,
  output logic [MET_W-1:0]  best_met
);
  import sd_pkg::*;

  function automatic logic [MET_W-1:0] sat_add(input logic [MET_W-1:0] a,
                                               input logic [MET_W-1:0] b);
    logic [MET_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MET_W] ? '1 : s[MET_W-1:0];
  endfunction

  function automatic logic [LVL_W-1:0] root_of(input logic [CNT_W-1:0] c);
    if (c < CNT_W'(2))             return LVL_W'(1);
    else if (c >= CNT_W'(MAX_ANT)) return LVL_W'(MAX_ANT - 1);
    else                           return LVL_W'(c - CNT_W'(1));
  endfunction

  dfs_state_e        state_q;
  logic [LVL_W-1:0]  lvl_q, root_q;
  logic [MET_W-1:0]  radius_q, best_met_q;
  logic [VEC_W-1:0]  best_vec_q;
  logic [VEC_W-1:0]  path_flat;
  logic [RANK_W-1:0] rd_rank;
  logic [MET_W-1:0]  rd_base, cand_met;

  // named internal events
  logic start_take, rsp_take, cand_ok, leaf_hit, go_down, go_up, finish;
  assign start_take = (state_q == S_IDLE) && start;
  assign rsp_take   = (state_q == S_WAIT) && rsp_valid;
  assign cand_met   = sat_add(rd_base, rsp_inc);
  assign cand_ok    = rsp_take && rsp_avail && (cand_met < radius_q);
  assign leaf_hit   = cand_ok && (lvl_q == '0);
  assign go_down    = cand_ok && (lvl_q != '0);
  assign go_up      = rsp_take && !cand_ok && (lvl_q != root_q);
  assign finish     = rsp_take && !cand_ok && (lvl_q == root_q);

  sd_path_store #(.DEPTH(MAX_ANT), .W(SYM_W)) u_path (
    .clk (clk), .rst_n (rst_n), .clr (start_take),
    .push(go_down), .pop (go_up), .din (rsp_sym), .flat (path_flat)
  );

  sd_level_mem #(.DEPTH(MAX_ANT), .LVL_W(LVL_W), .RANK_W(RANK_W), .MET_W(MET_W)) u_lvl (
    .clk     (clk), .rst_n (rst_n),
    .init    (start_take), .init_lvl (root_of(cfg_ant)),
    .bump    (cand_ok),    .bump_lvl (lvl_q),
    .desc    (go_down),    .desc_tgt (lvl_q - 1'b1), .desc_met (cand_met),
    .rd_lvl  (lvl_q),      .rd_rank  (rd_rank),      .rd_base  (rd_base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      lvl_q      <= '0;
      root_q     <= LVL_W'(1);
      radius_q   <= '1;
      best_met_q <= '1;
      best_vec_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q    <= S_ISSUE;
          root_q     <= root_of(cfg_ant);
          lvl_q      <= root_of(cfg_ant);
          radius_q   <= '1;
          best_met_q <= '1;
          best_vec_q <= '0;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          state_q <= finish ? S_FIN : S_ISSUE;
          if (leaf_hit) begin
            radius_q   <= cand_met;
            best_met_q <= cand_met;
            best_vec_q <= {path_flat[VEC_W-SYM_W-1:0], rsp_sym};
          end
          if (go_down) lvl_q <= lvl_q - 1'b1;
          if (go_up)   lvl_q <= lvl_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == S_ISSUE);
  assign req_level = lvl_q;
  assign req_rank  = rd_rank;
  assign busy      = (state_q == S_ISSUE) || (state_q == S_WAIT);
  assign done      = (state_q == S_FIN);
  assign best_vec  = best_vec_q;
  assign best_met  = best_met_q;

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_level <= root_q));
  a_r3_descend_rank0: assert property (@(posedge clk) disable iff (!rst_n)
    go_down |=> (req_valid && req_rank == '0));
  a_r4_backtrack_up: assert property (@(posedge clk) disable iff (!rst_n)
    go_up |=> (req_valid && req_level == LVL_W'($past(lvl_q) + 1'b1)));
  a_r5_radius_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> (radius_q <= $past(radius_q)));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> (cand_met >= rd_base));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
endmodule

// File: tb/test_sphere_dfs_ctrl.sv
module test_sphere_dfs_ctrl;
  localparam int MAX_ANT = 16, SYM_W = 6, MET_W = 16, RANK_W = 7;
  localparam int LVL_W = $clog2(MAX_ANT), CNT_W = $clog2(MAX_ANT + 1);
  localparam int VEC_W = MAX_ANT * SYM_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CNT_W-1:0] cfg_ant = '0;
  logic req_valid, busy, done;
  logic [LVL_W-1:0] req_level;
  logic [RANK_W-1:0] req_rank;
  logic rsp_valid = 0, rsp_avail = 0;
  logic [SYM_W-1:0] rsp_sym = '0;
  logic [MET_W-1:0] rsp_inc = '0;
  logic [VEC_W-1:0] best_vec;
  logic [MET_W-1:0] best_met;

  int n_chk = 0, n_bad = 0;
  int g_mode = 0, g_seed = 0;

  always #10 clk = ~clk;

  sphere_dfs_ctrl #(.MAX_ANT(MAX_ANT), .SYM_W(SYM_W), .MET_W(MET_W), .RANK_W(RANK_W))
    i_sphere_dfs_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_ant(cfg_ant),
      .req_valid(req_valid), .req_level(req_level), .req_rank(req_rank),
      .rsp_valid(rsp_valid), .rsp_avail(rsp_avail), .rsp_sym(rsp_sym), .rsp_inc(rsp_inc),
      .busy(busy), .done(done), .best_vec(best_vec), .best_met(best_met));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int satf(input int a, input int b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction
  function automatic int symf(input int l, input int r);
    return (r * 3 + l + 1) % 64;
  endfunction
  function automatic int incf(input int l, input int r, input int p, input int root);
    if (g_mode == 1) begin
      if (l == root) return 32768;
      return (p == symf(root, 0)) ? 32767 : 36864;
    end
    if (g_mode == 2) return (l == root) ? 2 : 3 + r * 2;
    return ((l * 7 + p * 5 + g_seed) % 13) + r * (((l + p + g_seed) % 4) + 1) * 2;
  endfunction

  // exhaustive reference: root rank varies slowest, strict improvement
  task automatic reference(input int n, input int k, output int emet, output logic [VEC_W-1:0] evec);
    int total = 1;
    for (int l = 0; l < n; l++) total *= k;
    emet = 65535; evec = '0;
    for (int idx = 0; idx < total; idx++) begin
      int r[MAX_ANT];
      int tmp = idx, met = 0, p = 0;
      logic [VEC_W-1:0] v = '0;
      for (int l = 0; l < n; l++) begin r[l] = tmp % k; tmp = tmp / k; end
      for (int l = n - 1; l >= 0; l--) begin
        met = satf(met, incf(l, r[l], p, n - 1));
        p = symf(l, r[l]);
        v[l*SYM_W +: SYM_W] = SYM_W'(p);
      end
      if (met < emet) begin emet = met; evec = v; end
    end
  endtask

  task automatic run_search(input int cfg, input int n, input int k, input int md, input int sd,
                            input bit glitch, input bit mid_start, input bit done_start,
                            input string tag);
    int root = n - 1, mrank[MAX_ANT], mbase[MAX_ANT], chosen[MAX_ANT];
    int rad = 65535, exp_lvl = n - 1, exp_rank = 0, nreq = 0, seq_bad = 0, guard = 0;
    int emet;
    bit exp_done = 0, got_done = 0;
    logic [VEC_W-1:0] evec;
    g_mode = md; g_seed = sd;
    for (int l = 0; l < MAX_ANT; l++) begin mrank[l] = 0; mbase[l] = 0; chosen[l] = 0; end
    reference(n, k, emet, evec);
    @(negedge clk); cfg_ant = CNT_W'(cfg); start = 1;
    @(negedge clk); start = 0;
    check(busy === 1'b1, {tag, " R1 busy after start"}, busy, 1);
    while (!got_done && guard < 20000) begin
      guard++;
      if (guard > 1) @(negedge clk);
      rsp_valid = 0; start = 0;
      if (done) begin
        got_done = 1;
        if (done_start) start = 1;
      end else if (req_valid) begin
        int lv = req_level, rk = req_rank, p, inc, cand;
        bit av;
        if (nreq == 0)
          check(lv == root && rk == 0, {tag, " R1 first request"}, lv * 256 + rk, root * 256);
        else if (exp_done || lv != exp_lvl || rk != exp_rank) seq_bad++;
        nreq++;
        p  = (lv == root) ? 0 : chosen[lv + 1];
        av = rk < k;
        inc = incf(lv, rk, p, root);
        if (glitch) begin
          rsp_valid = 1; rsp_avail = 1; rsp_inc = '0; rsp_sym = '1;
        end
        @(negedge clk);
        rsp_valid = 1; rsp_avail = av; rsp_sym = SYM_W'(symf(lv, rk)); rsp_inc = MET_W'(inc);
        if (mid_start && nreq == 3) begin start = 1; cfg_ant = CNT_W'(2); end
        if (av) chosen[lv] = symf(lv, rk);
        cand = satf(mbase[lv], inc);
        if (av && cand < rad) begin
          mrank[lv] = rk + 1;
          if (lv == 0) begin rad = cand; exp_lvl = 0; exp_rank = mrank[0]; end
          else begin mbase[lv-1] = cand; mrank[lv-1] = 0; exp_lvl = lv - 1; exp_rank = 0; end
        end else if (lv == root) exp_done = 1;
        else begin exp_lvl = lv + 1; exp_rank = mrank[lv + 1]; end
      end
    end
    check(got_done && exp_done, {tag, " R8 done when root exhausted"}, got_done, 1);
    check(seq_bad == 0, {tag, " R3/R4/R5 request sequence"}, seq_bad, 0);
    check(busy === 1'b0, {tag, " R8 busy low in done cycle"}, busy, 0);
    check(best_met == MET_W'(emet), {tag, " R5 best metric"}, best_met, emet);
    check(best_vec == evec, {tag, " R8 best vector"}, best_vec, evec);
    if (done_start) begin
      @(negedge clk); start = 0;
      @(negedge clk);
      check(!busy && !req_valid, {tag, " R9 start in done cycle ignored"}, busy, 0);
      rsp_valid = 1; rsp_avail = 1; rsp_inc = '0;
      @(negedge clk); rsp_valid = 0;
      @(negedge clk);
      check(!busy && !req_valid, {tag, " R2 idle response ignored"}, req_valid, 0);
      check(best_met == MET_W'(emet) && best_vec == evec, {tag, " R9 result held"}, best_met, emet);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(busy === 1'b0, "R8 reset busy", busy, 0);
    check(done === 1'b0, "R8 reset done", done, 0);
    check(req_valid === 1'b0, "R2 reset req_valid", req_valid, 0);
    check(best_met === 16'hFFFF, "R8 reset best_met", best_met, 16'hFFFF);
  endtask

  task automatic t_general;   run_search(4, 4, 4, 0, 1, 0, 0, 0, "gen4x4"); endtask
  task automatic t_glitch;    run_search(5, 5, 3, 0, 7, 1, 0, 0, "R2 glitch"); endtask
  task automatic t_mid_start; run_search(3, 3, 5, 0, 3, 0, 1, 0, "R9 mid start"); endtask
  task automatic t_ties;      run_search(2, 2, 2, 2, 0, 0, 0, 0, "R7 ties"); endtask
  task automatic t_saturate;  run_search(2, 2, 2, 1, 0, 0, 0, 0, "R6 saturate"); endtask
  task automatic t_clamp_low; run_search(1, 2, 3, 0, 5, 0, 0, 0, "R1 clamp low"); endtask
  task automatic t_clamp_hi;  run_search(20, 16, 1, 0, 2, 0, 0, 0, "R1 clamp high"); endtask
  task automatic t_done_start; run_search(3, 3, 3, 0, 9, 0, 0, 1, "R9 done start"); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_general;
    t_glitch;
    t_mid_start;
    t_ties;
    t_saturate;
    t_clamp_low;
    t_clamp_hi;
    t_done_start;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule